// File: doc/BRIEF.md
# PCI Target Back-End Decoder with Burst Address Tracking

This block sits behind a PCI target core and in front of a small register array. During the single address-phase cycle of a transaction it classifies the bus command into a user-read or user-write request. It also checks the address against a memory window and an I/O window, each gated by its own space-enable bit, and returns the flags and the select to the core in that same cycle.

The address appears only once per burst. The block latches it as a dword address and advances it by four on every completed transfer. Writes complete on each increment strobe whether or not the back end is ready. Reads complete only when the increment strobe coincides with the block's own ready. Write data lands in the register array under active-low byte enables. Read data is always prefetched for the current address, so a back-end hold is the only source of read wait states.

Top module: `pcib_top`

## Requirements
- R1: While the address-valid strobe is high, `dec_rd_o` is high exactly for commands 4'h2, 4'h6, 4'hC and 4'hE. While the strobe is low, `dec_rd_o`, `dec_wr_o` and `sel_o` are all low.
- R2: While the strobe is high, `dec_wr_o` is high exactly for commands 4'h3 and 4'h7. Command 4'hF raises it only when `MWI_WRITE` is 1, and the default is 0. Configuration commands (4'hA, 4'hB), special cycle 4'h1 and the others raise no flag.
- R3: `sel_o` is high when a memory command (4'h6, 4'h7, 4'hC, 4'hE, 4'hF) carries an address whose bits above the window size match `mem_bar_i` and `mem_en_i` is high. It is also high when an I/O command (4'h2, 4'h3) carries an address matching `io_bar_i` and `io_en_i` is high. In every other case it is low. The window spans DEPTH dwords (64 bytes by default).
- R4: The cycle after the strobe, `cur_addr_o` holds the strobed address with its two low bits cleared.
- R5: In a selected read, the address advances by 4 only in cycles where `adr_inc_i` and `rdy_o` are both high.
- R6: In a selected write, every cycle with `adr_inc_i` and `wr_act_i` high stores a dword and advances the address by 4, whatever the state of `hold_i`. Cycles without the increment strobe leave the address unchanged.
- R7: On a stored write, byte lane b (bits 8b+7..8b) is written only when `cbe_i[b]` is low. Other lanes keep their contents.
- R8: `rdy_o` is high exactly when the current transaction is a selected read and `hold_i` is low. It is never high during writes.
- R9: From the cycle after the address phase, `rd_data_o` shows the array word at index `cur_addr_o[5:2]` (default depth). The index wraps modulo DEPTH during long bursts.
- R10: A transaction that was not selected, or that raised neither flag (for example 4'hF by default), stores nothing, raises no ready and does not advance the address.
- R11: After reset, `cur_addr_o`, `rdy_o` and `rd_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adr_vld_i | input | 1 | Address-phase strobe from the core |
| adr_inc_i | input | 1 | Transfer/increment strobe from the core |
| wr_act_i | input | 1 | User write in progress, from the core |
| addr_data_i | input | 32 | Address in the address phase, write data afterwards |
| cbe_i | input | 4 | Command in the address phase, active-low byte enables afterwards |
| mem_bar_i | input | 32 | Memory window base |
| io_bar_i | input | 32 | I/O window base |
| mem_en_i | input | 1 | Memory space enable |
| io_en_i | input | 1 | I/O space enable |
| hold_i | input | 1 | Back end busy; withholds read ready |
| dec_rd_o | output | 1 | User-read command decoded |
| dec_wr_o | output | 1 | User-write command decoded |
| sel_o | output | 1 | Address hits an enabled window |
| rdy_o | output | 1 | Back-end ready for read transfers |
| rd_data_o | output | 32 | Read data for the current address |
| cur_addr_o | output | 32 | Running dword address |

## Verification
Two functions can meet in one cycle: the increment strobe and a back-end hold. A write beat issued with `hold_i` high must still store its data and advance the address. A read beat under hold must neither advance nor deliver data. The bench drives bursts in which hold alternates with the strobe during both writes and reads. It judges writes by reading the array back later through a selected read. It judges reads by a scoreboard that expects one word per unheld beat, with address checks after the held cycles.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

  typedef enum logic [3:0] {
    CMD_INTA  = 4'h0,
    CMD_SPEC  = 4'h1,
    CMD_IORD  = 4'h2,
    CMD_IOWR  = 4'h3,
    CMD_MRD   = 4'h6,
    CMD_MWR   = 4'h7,
    CMD_CFGRD = 4'hA,
    CMD_CFGWR = 4'hB,
    CMD_MRM   = 4'hC,
    CMD_DAC   = 4'hD,
    CMD_MRL   = 4'hE,
    CMD_MWI   = 4'hF
  } pci_cmd_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic mem;
    logic io;
  } cmd_class_t;

  localparam int NSPACE = 2;
  localparam int SP_IO  = 0;
  localparam int SP_MEM = 1;

endpackage

// File: rtl/pcib_cmd_decode.sv
module pcib_cmd_decode
  import pcib_pkg::*;
#(
  parameter bit MWI_WRITE = 1'b0
) (
  input  logic [3:0]  cmd_i,
  output cmd_class_t  cls_o
);

  always_comb begin
    cls_o = '0;
    case (pci_cmd_e'(cmd_i))
      CMD_IORD: begin cls_o.rd = 1'b1; cls_o.io = 1'b1; end
      CMD_IOWR: begin cls_o.wr = 1'b1; cls_o.io = 1'b1; end
      CMD_MRD, CMD_MRM, CMD_MRL: begin
        cls_o.rd  = 1'b1;
        cls_o.mem = 1'b1;
      end
      CMD_MWR: begin cls_o.wr = 1'b1; cls_o.mem = 1'b1; end
      CMD_MWI: begin
        cls_o.wr  = MWI_WRITE;
        cls_o.mem = 1'b1;
      end
      default: cls_o = '0;
    endcase
  end

endmodule

// File: rtl/pcib_bar_match.sv
module pcib_bar_match #(
  parameter int ADDR_W = 32,
  parameter int WIN_LG = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              en_i,
  input  logic              want_i,
  output logic              hit_o
);

  localparam logic [ADDR_W-1:0] TAG_MASK = {ADDR_W{1'b1}} << WIN_LG;

  always_comb hit_o = want_i && en_i && (((addr_i ^ base_i) & TAG_MASK) == '0);

endmodule

// File: rtl/pcib_addr_track.sv
module pcib_addr_track #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [IDX_W-1:0]  nxt_idx_o
);

  logic [ADDR_W-1:0] cur_q, nxt;

  always_comb begin
    if (load_i)      nxt = load_addr_i & ~ADDR_W'(3);
    else if (step_i) nxt = cur_q + ADDR_W'(4);
    else             nxt = cur_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= '0;
    else     cur_q <= nxt;
  end

  assign cur_addr_o = cur_q;
  assign nxt_idx_o  = nxt[IDX_W+1:2];

endmodule

// File: rtl/pcib_reg_array.sv
module pcib_reg_array #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int DW    = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [LANES-1:0] be_n_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rdata_o
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) begin
      for (int b = 0; b < LANES; b++) begin
        if (!be_n_i[b]) mem_q[wr_idx_i][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= mem_q[rd_idx_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/pcib_top.sv
module pcib_top
  import pcib_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter bit MWI_WRITE = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        adr_vld_i,
  input  logic        adr_inc_i,
  input  logic        wr_act_i,
  input  logic [31:0] addr_data_i,
  input  logic [3:0]  cbe_i,
  input  logic [31:0] mem_bar_i,
  input  logic [31:0] io_bar_i,
  input  logic        mem_en_i,
  input  logic        io_en_i,
  input  logic        hold_i,
  output logic        dec_rd_o,
  output logic        dec_wr_o,
  output logic        sel_o,
  output logic        rdy_o,
  output logic [31:0] rd_data_o,
  output logic [31:0] cur_addr_o
);

  localparam int ADDR_W = 32;
  localparam int LANES  = 4;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int WIN_LG = IDX_W + 2;

  cmd_class_t        cls;
  logic [NSPACE-1:0] sp_want, sp_en, sp_hit;
  logic [ADDR_W-1:0] sp_base [NSPACE];
  logic              rd_q, wr_q;
  logic              wr_xfer, rd_xfer;
  logic [IDX_W-1:0]  nxt_idx;

  pcib_cmd_decode #(.MWI_WRITE(MWI_WRITE)) u_dec (
    .cmd_i (cbe_i),
    .cls_o (cls)
  );

  always_comb begin
    sp_want[SP_IO]  = cls.io;
    sp_want[SP_MEM] = cls.mem;
    sp_en[SP_IO]    = io_en_i;
    sp_en[SP_MEM]   = mem_en_i;
    sp_base[SP_IO]  = io_bar_i;
    sp_base[SP_MEM] = mem_bar_i;
  end

  for (genvar s = 0; s < NSPACE; s++) begin : g_space
    pcib_bar_match #(.ADDR_W(ADDR_W), .WIN_LG(WIN_LG)) u_match (
      .addr_i (addr_data_i),
      .base_i (sp_base[s]),
      .en_i   (sp_en[s]),
      .want_i (sp_want[s]),
      .hit_o  (sp_hit[s])
    );
  end

  assign dec_rd_o = adr_vld_i & cls.rd;
  assign dec_wr_o = adr_vld_i & cls.wr;
  assign sel_o    = adr_vld_i & (|sp_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else if (adr_vld_i) begin
      rd_q <= (|sp_hit) & cls.rd;
      wr_q <= (|sp_hit) & cls.wr;
    end
  end

  assign rdy_o   = rd_q & ~hold_i;
  assign wr_xfer = wr_q & wr_act_i & adr_inc_i & ~adr_vld_i;
  assign rd_xfer = rd_q & adr_inc_i & ~hold_i & ~adr_vld_i;

  pcib_addr_track #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_track (
    .clk         (clk),
    .rst         (rst),
    .load_i      (adr_vld_i),
    .load_addr_i (addr_data_i),
    .step_i      (wr_xfer | rd_xfer),
    .cur_addr_o  (cur_addr_o),
    .nxt_idx_o   (nxt_idx)
  );

  pcib_reg_array #(.DEPTH(DEPTH), .LANES(LANES)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .we_i     (wr_xfer),
    .wr_idx_i (cur_addr_o[WIN_LG-1:2]),
    .be_n_i   (cbe_i),
    .wdata_i  (addr_data_i),
    .rd_idx_i (nxt_idx),
    .rdata_o  (rd_data_o)
  );

endmodule

// File: rtl/pcib_checker.sv
module pcib_checker (
  input logic        clk,
  input logic        rst,
  input logic        adr_vld_i,
  input logic        adr_inc_i,
  input logic        hold_i,
  input logic        mem_en_i,
  input logic        io_en_i,
  input logic [31:0] addr_data_i,
  input logic [31:0] cur_addr_o,
  input logic        rdy_o,
  input logic        dec_rd_o,
  input logic        dec_wr_o,
  input logic        sel_o
);

  assert_no_decode_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !adr_vld_i |-> !(dec_rd_o || dec_wr_o || sel_o));

  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(dec_rd_o && dec_wr_o));

  assert_sel_gated_R3: assert property (@(posedge clk) disable iff (rst)
    (!mem_en_i && !io_en_i) |-> !sel_o);

  assert_addr_latch_R4: assert property (@(posedge clk) disable iff (rst)
    adr_vld_i |=> cur_addr_o == {$past(addr_data_i[31:2]), 2'b00});

  assert_dword_align_R4: assert property (@(posedge clk) disable iff (rst)
    cur_addr_o[1:0] == 2'b00);

  assert_read_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (!adr_vld_i && adr_inc_i && rdy_o) |=> cur_addr_o == $past(cur_addr_o) + 32'd4);

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!adr_vld_i && !adr_inc_i) |=> $stable(cur_addr_o));

  assert_hold_blocks_ready_R8: assert property (@(posedge clk) disable iff (rst)
    hold_i |-> !rdy_o);

endmodule

bind pcib_top pcib_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .adr_vld_i   (adr_vld_i),
  .adr_inc_i   (adr_inc_i),
  .hold_i      (hold_i),
  .mem_en_i    (mem_en_i),
  .io_en_i     (io_en_i),
  .addr_data_i (addr_data_i),
  .cur_addr_o  (cur_addr_o),
  .rdy_o       (rdy_o),
  .dec_rd_o    (dec_rd_o),
  .dec_wr_o    (dec_wr_o),
  .sel_o       (sel_o)
);

// File: tb/tb_pcib_top.sv
module tb_pcib_top;

  localparam int CLK_P = 10;
  localparam int DEPTH = 16;
  localparam logic [31:0] MEM_BAR = 32'h4000_0000;
  localparam logic [31:0] IO_BAR  = 32'h0000_1000;

  logic        clk, rst, adr_vld_i, adr_inc_i, wr_act_i;
  logic [31:0] addr_data_i, mem_bar_i, io_bar_i;
  logic [3:0]  cbe_i;
  logic        mem_en_i, io_en_i, hold_i;
  logic        dec_rd_o, dec_wr_o, sel_o, rdy_o;
  logic [31:0] rd_data_o, cur_addr_o;

  pcib_top dut (
    .clk(clk), .rst(rst), .adr_vld_i(adr_vld_i), .adr_inc_i(adr_inc_i),
    .wr_act_i(wr_act_i), .addr_data_i(addr_data_i), .cbe_i(cbe_i),
    .mem_bar_i(mem_bar_i), .io_bar_i(io_bar_i), .mem_en_i(mem_en_i),
    .io_en_i(io_en_i), .hold_i(hold_i), .dec_rd_o(dec_rd_o),
    .dec_wr_o(dec_wr_o), .sel_o(sel_o), .rdy_o(rdy_o),
    .rd_data_o(rd_data_o), .cur_addr_o(cur_addr_o)
  );

  int          checks = 0;
  int          fails  = 0;
  bit          done   = 0;
  logic [31:0] exp_q[$];
  logic [31:0] model [DEPTH];
  logic [31:0] exp_addr = '0;

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: one expected word per completed read beat
  always @(negedge clk) begin
    if (!rst && adr_inc_i && rdy_o) begin
      if (exp_q.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R9 unexpected read transfer actual=%h expected=none", rd_data_o);
      end else begin
        chk("R9 read data", rd_data_o, exp_q.pop_front());
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int idx_of(input logic [31:0] a);
    return int'(a[5:2]);
  endfunction

  task automatic phase(input logic [3:0] cmd, input logic [31:0] a, input bit exp_sel, input string tag);
    adr_vld_i = 1'b1; cbe_i = cmd; addr_data_i = a;
    adr_inc_i = 1'b0; wr_act_i = 1'b0; hold_i = 1'b0;
    @(negedge clk);
    chk(tag, {31'b0, sel_o}, {31'b0, exp_sel});
    tick();
    adr_vld_i = 1'b0; cbe_i = 4'h0;
    exp_addr = {a[31:2], 2'b00};
  endtask

  task automatic chk_addr(input string tag);
    adr_inc_i = 1'b0;
    @(negedge clk);
    chk(tag, cur_addr_o, exp_addr);
    tick();
  endtask

  task automatic wr_beat(input logic [31:0] d, input logic [3:0] be_n, input bit hold, input bit hit);
    adr_inc_i = 1'b1; wr_act_i = 1'b1; addr_data_i = d; cbe_i = be_n; hold_i = hold;
    @(negedge clk);
    chk("R8 no ready during write", {31'b0, rdy_o}, 32'd0);
    tick();
    if (hit) begin
      for (int b = 0; b < 4; b++)
        if (!be_n[b]) model[idx_of(exp_addr)][8*b +: 8] = d[8*b +: 8];
      exp_addr += 32'd4;
    end
    adr_inc_i = 1'b0; hold_i = 1'b0;
  endtask

  task automatic rd_beat(input bit hold, input bit hit);
    adr_inc_i = 1'b1; hold_i = hold;
    if (hit && !hold) exp_q.push_back(model[idx_of(exp_addr)]);
    @(negedge clk);
    chk("R8 read ready", {31'b0, rdy_o}, {31'b0, hit && !hold});
    tick();
    if (hit && !hold) exp_addr += 32'd4;
    adr_inc_i = 1'b0; hold_i = 1'b0;
  endtask

  task automatic end_xact();
    wr_act_i = 1'b0; adr_inc_i = 1'b0; hold_i = 1'b0;
    tick();
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; adr_vld_i = 1'b0; adr_inc_i = 1'b0; wr_act_i = 1'b0;
    addr_data_i = '0; cbe_i = '0; mem_bar_i = MEM_BAR; io_bar_i = IO_BAR;
    mem_en_i = 1'b1; io_en_i = 1'b1; hold_i = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    chk("R11 reset address", cur_addr_o, 32'd0);
    chk("R11 reset ready", {31'b0, rdy_o}, 32'd0);
    chk("R11 reset read data", rd_data_o, 32'd0);
    tick();

    // R1 R2 R3: command sweep against both windows
    for (int w = 0; w < 2; w++) begin
      for (int c = 0; c < 16; c++) begin
        bit er, ew, em, ei;
        er = (c == 2) || (c == 6) || (c == 12) || (c == 14);
        ew = (c == 3) || (c == 7);
        em = (c == 6) || (c == 7) || (c == 12) || (c == 14) || (c == 15);
        ei = (c == 2) || (c == 3);
        adr_vld_i = 1'b1; cbe_i = 4'(c);
        addr_data_i = (w == 0) ? MEM_BAR + 32'h20 : IO_BAR + 32'h4;
        @(negedge clk);
        chk("R1 read flag", {31'b0, dec_rd_o}, {31'b0, er});
        chk("R2 write flag", {31'b0, dec_wr_o}, {31'b0, ew});
        chk("R3 select", {31'b0, sel_o}, {31'b0, (w == 0) ? em : ei});
        tick();
      end
    end
    adr_vld_i = 1'b0; cbe_i = 4'h6; addr_data_i = MEM_BAR;
    @(negedge clk);
    chk("R1 no flag without strobe", {30'b0, dec_rd_o, sel_o}, 32'd0);
    tick();

    // R3 gating and window edges
    mem_en_i = 1'b0;
    phase(4'h6, MEM_BAR, 1'b0, "R3 memory disabled");
    mem_en_i = 1'b1; io_en_i = 1'b0;
    phase(4'h2, IO_BAR, 1'b0, "R3 io disabled");
    io_en_i = 1'b1;
    phase(4'h6, MEM_BAR + 32'h40, 1'b0, "R3 just past window");
    phase(4'h6, MEM_BAR + 32'h3F, 1'b1, "R3 last byte of window");
    chk_addr("R4 latched address drops low bits");

    // R6: fill every word, holds alternate with increments
    phase(4'h7, MEM_BAR, 1'b1, "R3 write select");
    chk_addr("R4 write start address");
    for (int i = 0; i < DEPTH; i++) begin
      wr_beat(32'hA500_0000 ^ (32'h0101_0101 * 32'(i)) ^ 32'(i), 4'h0, i[0], 1'b1);
      if (i == 5) begin
        wr_act_i = 1'b1;
        chk_addr("R6 no advance without strobe");
      end
    end
    chk_addr("R6 write advanced under hold");
    end_xact();

    // R7: byte lanes 0 and 2 only
    phase(4'h7, MEM_BAR + 32'h0C, 1'b1, "R3 byte write select");
    wr_beat(32'hDEAD_BEEF, 4'b1010, 1'b0, 1'b1);
    end_xact();

    // R10: unselected write and unmapped write-invalidate
    phase(4'h7, 32'h5000_0000, 1'b0, "R10 unselected write");
    wr_beat(32'hFFFF_FFFF, 4'h0, 1'b0, 1'b0);
    chk_addr("R10 no advance unselected");
    end_xact();
    phase(4'hF, MEM_BAR + 32'h10, 1'b1, "R10 mwi selected");
    wr_beat(32'h0000_0000, 4'h0, 1'b0, 1'b0);
    chk_addr("R10 mwi no advance");
    end_xact();

    // R5 R9: read burst with holds
    phase(4'h6, MEM_BAR, 1'b1, "R3 read select");
    rd_beat(1'b0, 1'b1);
    rd_beat(1'b1, 1'b1);
    chk_addr("R5 no advance under hold");
    for (int i = 0; i < 5; i++) rd_beat(i == 2, 1'b1);
    chk_addr("R5 read advance");
    end_xact();

    // R9 wrap past the last index
    phase(4'hE, MEM_BAR + 32'h38, 1'b1, "R3 read line select");
    for (int i = 0; i < 4; i++) rd_beat(1'b0, 1'b1);
    chk_addr("R9 address after wrap");
    end_xact();

    // I/O window read and multiple-read
    phase(4'h2, IO_BAR + 32'h08, 1'b1, "R3 io select");
    rd_beat(1'b0, 1'b1);
    rd_beat(1'b0, 1'b1);
    end_xact();
    phase(4'hC, MEM_BAR + 32'h24, 1'b1, "R3 read multiple select");
    rd_beat(1'b0, 1'b1);
    end_xact();

    // R10 unselected read
    phase(4'h6, 32'h5000_0000, 1'b0, "R10 unselected read");
    rd_beat(1'b0, 1'b0);
    chk_addr("R10 unselected read no advance");
    end_xact();

    chk("R9 scoreboard drained", 32'(exp_q.size()), 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule